// File: doc/BRIEF.md
# Buffered Input Capture Unit

This block records the value of an externally supplied 16-bit free-running count whenever a chosen transition appears on an asynchronous capture input. The input is first brought into the clock domain by a short flip-flop chain. A small edge-tracking state machine then turns level changes into single-cycle rise and fall events, and a capture controller loads the count into one of two 16-bit registers.

Two register arrangements are available. In independent mode each register is its own capture channel with its own edge select. In buffer mode the two form a chain: every accepted edge writes the count into the primary register and moves the primary's previous content into the buffer register. With the two edge selects set differently, the chain accepts both rising and falling edges, which lets software read the last two transition times of a pulse from one channel. A registered flag pair reports each capture for one cycle, and a word-wide read port returns either register.

The edge-tracking machine has three states. `EDG_INIT` is entered on reset and waits until the synchroniser holds a real sample, then goes to `EDG_LOW` or `EDG_HIGH` matching that level, without raising an event. From `EDG_LOW`, a high sample moves to `EDG_HIGH` and raises a rise event. From `EDG_HIGH`, a low sample moves to `EDG_LOW` and raises a fall event. Any other sample keeps the current state.

Top module: `icap_buf_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it, both capture registers read 0x0000 and both `cap_flag` bits are 0.
- R2: In independent mode, the primary register captures when `cap_pin` rises if `edge_sel_p`=1, or when it falls if `edge_sel_p`=0. The stored value is `cnt_val` as sampled at the third rising clock edge after the pin change, and it is visible just after that edge.
- R3: In independent mode, the buffer register captures in the same way and with the same latency, using `edge_sel_b` to choose its edge.
- R4: In buffer mode (`buf_mode`=1), each accepted edge loads `cnt_val` into the primary register. On that same edge, the buffer register receives the value the primary held just before.
- R5: In buffer mode, an edge is accepted if it matches either edge select. When the selects differ, both rising and falling edges capture. When they are equal, only the selected edge captures.
- R6: `cap_flag[0]` is high for exactly one cycle after each primary capture. `cap_flag[1]` is high for exactly one cycle after each independent buffer-channel capture. `cap_flag[1]` stays 0 in buffer mode.
- R7: `rd_data` shows the full 16-bit primary register when `rd_sel`=0 and the full buffer register when `rd_sel`=1. There is no partial-width access.
- R8: An edge that no active select chooses leaves both registers unchanged and both flags low.
- R9: A level that is already present on `cap_pin` when reset ends does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_val | input | 16 | Free-running counter value |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_sel_p | input | 1 | Primary edge select (1 = rising, 0 = falling) |
| edge_sel_b | input | 1 | Buffer edge select (1 = rising, 0 = falling) |
| buf_mode | input | 1 | 1 = chain buffer behind primary |
| rd_sel | input | 1 | Read select (0 = primary, 1 = buffer) |
| rd_data | output | 16 | Selected capture register |
| cap_flag | output | 2 | Per-register capture pulse |

## Verification
If the edge-tracking state is wrong, the result shows up at the ports within three cycles of the next pin change. It appears either as a missing or extra flag pulse, or as a capture of the wrong count. If the chain ordering is wrong, the buffer register returns a stale or freshly captured value on the first chained edge, which the next read exposes. A sweep over every mode and select combination with alternating edges compares each register and flag against arithmetic expectations, so a fault in any branch of the state machine or the capture decode appears within one edge of its cause.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDG_INIT = 2'd0,
        EDG_LOW  = 2'd1,
        EDG_HIGH = 2'd2
    } edge_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/icap_edge_fsm.sv
module icap_edge_fsm
    import icap_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise_o,
    output logic fall_o
);
    localparam int WAIT_W = $clog2(SETTLE + 1);
    localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(SETTLE);

    edge_state_t st_q, st_nxt;
    logic [WAIT_W-1:0] wait_q;
    edge_evt_t evt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= EDG_INIT;
            wait_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (st_q == EDG_INIT && wait_q != WAIT_MAX) begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            EDG_INIT: if (wait_q == WAIT_MAX) st_nxt = lvl ? EDG_HIGH : EDG_LOW;
            EDG_LOW:  if (lvl)  st_nxt = EDG_HIGH;
            EDG_HIGH: if (!lvl) st_nxt = EDG_LOW;
            default:  st_nxt = EDG_INIT;
        endcase
    end

    // outputs
    always_comb begin
        evt = '0;
        unique case (st_q)
            EDG_LOW:  evt.rise = lvl;
            EDG_HIGH: evt.fall = !lvl;
            default:  evt = '0;
        endcase
    end

    assign rise_o = evt.rise;
    assign fall_o = evt.fall;

    a_r8_edge_excl: assert property (@(posedge clk) disable iff (rst)
        !(rise_o && fall_o));
    a_r9_init_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == EDG_INIT) |-> (!rise_o && !fall_o));
    a_r2_rise_moves_high: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> (st_q == EDG_HIGH));
    a_r2_fall_moves_low: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> (st_q == EDG_LOW));
endmodule

// File: rtl/icap_cap_ctrl.sv
module icap_cap_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fall,
    input  logic          sel_p,
    input  logic          sel_b,
    input  logic          buf_mode,
    input  logic [CW-1:0] cnt_val,
    output logic [CW-1:0] prim_o,
    output logic [CW-1:0] buf_o,
    output logic [1:0]    flag_o
);
    logic [CW-1:0] prim_q, buf_q;
    logic [1:0]    flag_q;
    logic          hit_p, hit_b;

    assign hit_p = sel_p ? rise : fall;
    assign hit_b = sel_b ? rise : fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            buf_q  <= '0;
            flag_q <= '0;
        end else if (buf_mode) begin
            flag_q <= {1'b0, hit_p | hit_b};
            if (hit_p | hit_b) begin
                prim_q <= cnt_val;
                buf_q  <= prim_q;
            end
        end else begin
            flag_q <= {hit_b, hit_p};
            if (hit_p) prim_q <= cnt_val;
            if (hit_b) buf_q  <= cnt_val;
        end
    end

    assign prim_o = prim_q;
    assign buf_o  = buf_q;
    assign flag_o = flag_q;

    a_r4_chain_shift: assert property (@(posedge clk) disable iff (rst)
        (buf_mode && (hit_p || hit_b)) |=> (buf_q == $past(prim_q)) && (prim_q == $past(cnt_val)));
    a_r6_no_buf_flag: assert property (@(posedge clk) disable iff (rst)
        buf_mode |=> !flag_q[1]);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prim_q == '0 && buf_q == '0 && flag_q == 2'b00));
    a_r8_prim_hold: assert property (@(posedge clk) disable iff (rst)
        (!hit_p && !(buf_mode && hit_b)) |=> $stable(prim_q));
endmodule

// File: rtl/icap_buf_unit.sv
module icap_buf_unit #(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_val,
    input  logic          cap_pin,
    input  logic          edge_sel_p,
    input  logic          edge_sel_b,
    input  logic          buf_mode,
    input  logic          rd_sel,
    output logic [CW-1:0] rd_data,
    output logic [1:0]    cap_flag
);
    logic          pin_s, rise, fall;
    logic [CW-1:0] prim, bufr;

    icap_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d_async(cap_pin), .d_sync(pin_s)
    );

    icap_edge_fsm #(.SETTLE(SYNC_STAGES)) edge_i (
        .clk(clk), .rst(rst), .lvl(pin_s), .rise_o(rise), .fall_o(fall)
    );

    icap_cap_ctrl #(.CW(CW)) ctrl_i (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall),
        .sel_p(edge_sel_p), .sel_b(edge_sel_b), .buf_mode(buf_mode),
        .cnt_val(cnt_val), .prim_o(prim), .buf_o(bufr), .flag_o(cap_flag)
    );

    assign rd_data = rd_sel ? bufr : prim;

    a_r6_flag_chain_one: assert property (@(posedge clk) disable iff (rst)
        (buf_mode && $past(buf_mode)) |-> (cap_flag != 2'b11));
endmodule

// File: tb/icap_buf_unit_tb_top.sv
`timescale 1ns/1ps
module icap_buf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = 16'h1200;
    logic        cap_pin = 1'b0;
    logic        edge_sel_p = 1'b1, edge_sel_b = 1'b0, buf_mode = 1'b0, rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic [1:0]  cap_flag;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    icap_buf_unit dut_i (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cap_pin(cap_pin),
        .edge_sel_p(edge_sel_p), .edge_sel_b(edge_sel_b), .buf_mode(buf_mode),
        .rd_sel(rd_sel), .rd_data(rd_data), .cap_flag(cap_flag)
    );

    task automatic tick();
        @(negedge clk);
        cnt_val = cnt_val + 16'd1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_both(output logic [15:0] p, output logic [15:0] b);
        rd_sel = 1'b0; #0.2; p = rd_data;
        rd_sel = 1'b1; #0.2; b = rd_data;
        rd_sel = 1'b0;
    endtask

    task automatic do_reset(input logic pin_lvl);
        logic [15:0] p, b;
        rst = 1'b1; cap_pin = pin_lvl;
        repeat (3) tick();
        read_both(p, b);
        chk("R1 prim in reset", p, 16'h0);
        chk("R1 flag in reset", {14'b0, cap_flag}, 16'h0);
        rst = 1'b0;
        tick();
        read_both(p, b);
        chk("R1 prim after reset", p, 16'h0);
        chk("R1 buf after reset", b, 16'h0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9 no edge from reset level", {14'b0, cap_flag}, 16'h0);
        end
    endtask

    logic [15:0] ep, eb;

    task automatic do_edge(input logic lvl);
        logic [15:0] c0, p, b;
        logic hp, hb;
        logic [1:0] ef;
        string tp, tb;
        cap_pin = lvl;
        c0 = cnt_val;
        repeat (3) tick();
        hp = edge_sel_p ? lvl : !lvl;
        hb = edge_sel_b ? lvl : !lvl;
        if (buf_mode) begin
            tp = (edge_sel_p != edge_sel_b) ? "R5 both-edge prim" : "R4 chain prim";
            tb = (edge_sel_p != edge_sel_b) ? "R5 both-edge buf" : "R4 chain buf";
            if (hp | hb) begin
                eb = ep; ep = c0 + 16'd2; ef = 2'b01;
            end else begin
                ef = 2'b00; tp = "R8 ignored edge prim"; tb = "R8 ignored edge buf";
            end
        end else begin
            tp = hp ? "R2 prim capture" : "R8 prim unchanged";
            tb = hb ? "R3 buf capture" : "R8 buf unchanged";
            if (hp) ep = c0 + 16'd2;
            if (hb) eb = c0 + 16'd2;
            ef = {hb, hp};
        end
        read_both(p, b);
        chk(tp, p, ep);
        chk(tb, b, eb);
        chk("R6 flag pulse", {14'b0, cap_flag}, {14'b0, ef});
        tick();
        chk("R6 flag one cycle", {14'b0, cap_flag}, 16'h0);
    endtask

    initial begin
        do_reset(1'b1);
        ep = 16'h0; eb = 16'h0;
        do_edge(1'b0);
        for (int cfg = 0; cfg < 8; cfg++) begin
            edge_sel_p = cfg[0];
            edge_sel_b = cfg[1];
            buf_mode   = cfg[2];
            do_reset(1'b0);
            ep = 16'h0; eb = 16'h0;
            for (int e = 0; e < 6; e++) begin
                do_edge(e[0] ? 1'b0 : 1'b1);
                repeat (e + 1) tick();
            end
            begin
                logic [15:0] p, b;
                rd_sel = 1'b1; #0.2; b = rd_data;
                chk("R7 read buffer word", b, eb);
                rd_sel = 1'b0; #0.2; p = rd_data;
                chk("R7 read primary word", p, ep);
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule